// File: doc/BRIEF.md
# Ring Generator Scan Decompressor

This block expands a narrow tester data stream into stimulus for many scan chains. A register of `RING_W` stages recirculates with internal polynomial feedback. On every shift cycle, each of the `IN_W` tester bits is folded into the ring at two separate stages. These injection points are separate from the feedback taps. When no tester data is injected, the ring simply runs through its polynomial sequence. Injected data steers it away from that sequence, cycle by cycle.

A phase shifter made of XOR gates drives the `CHAINS` scan chain inputs. Each chain gets the XOR of its own set of three ring stages, so neighbouring chains do not carry shifted copies of one stream. The ring moves only while shift enable is high. A synchronous clear sets it back to zero before a new pattern is loaded. The surrounding test flow may spend several loading cycles before the chains begin to capture. Working out the data to inject for a given test cube is done off-chip.

Top module: `ring_decomp`

## Requirements
- R1: After asynchronous reset (`rst_n` low), every ring stage is 0, so every chain output is 0.
- R2: While `shift_en` is low and `clr` is low, the ring holds its value, and the chain outputs stay unchanged across clock edges.
- R3: When `clr` is high at a clock edge, the ring becomes all zeros. This takes priority over `shift_en` and over any tester data.
- R4: Consider a shift cycle with all tester bits zero. Each stage i (for i < RING_W-1) takes stage i+1, and stage RING_W-1 takes stage 0. Stage 0's old value is also XORed into every stage i < RING_W-1 whose bit i in `POLY` is 1.
- R5: On a shift cycle, tester bit k is XORed into the next value of two stages, k*S and k*S + S/2, where S = RING_W/IN_W. This comes on top of the R4 feedback. Starting from an all-zero ring, the result therefore has exactly twice as many ones as the injected word.
- R6: Tester data has no effect while `shift_en` is low.
- R7: Chain output j is the XOR of three ring stages: j mod RING_W, (5j+1) mod RING_W and (9j+2) mod RING_W. It is combinational from the ring, so it follows the ring state after each edge.
- R8: An all-zero ring with all-zero tester input stays all-zero through shift cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous ring clear |
| shift_en | input | 1 | Advance ring and chains |
| tester_i | input | IN_W | Tester bits injected this cycle |
| chain_o | output | CHAINS | Scan chain inputs |

## Verification
The bench compares every chain bit, after every edge, against a software model of the ring and phase shifter. It injects single-bit words into a cleared ring to expose injection points placed at the wrong stage. A design with a wrong stage gives the wrong chain pattern on the very next cycle. Long zero-input runs after loading cover the feedback taps and the wrap from stage 0 to the top. A missing or misplaced tap only shows up after stage 0 has carried a one. Held cycles with busy tester data, and a clear raised together with shift and data, catch two faults. A design that lets data leak in while held, or that gives shift priority over clear, leaves a nonzero pattern where zero or the held value is expected.

// File: rtl/ring_decomp.sv
module ring_decomp #(
  parameter int RING_W = 32,
  parameter int IN_W   = 4,
  parameter int CHAINS = 16,
  parameter logic [RING_W-1:0] POLY = 32'h0020_0047
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [IN_W-1:0]   tester_i,
  output logic [CHAINS-1:0] chain_o
);
  localparam int SPAN = RING_W / IN_W;
  localparam int HALF = SPAN / 2;
  localparam logic [RING_W-1:0] TAPS = POLY & ~(RING_W'(1) << (RING_W-1));

  logic [RING_W-1:0] ring_q, fb, inj;

  assign fb = {ring_q[0], ring_q[RING_W-1:1]} ^ ({RING_W{ring_q[0]}} & TAPS);

  always_comb begin
    inj = '0;
    for (int k = 0; k < IN_W; k++) begin
      inj[k*SPAN]      = inj[k*SPAN]      ^ tester_i[k];
      inj[k*SPAN+HALF] = inj[k*SPAN+HALF] ^ tester_i[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ring_q <= '0;
    else if (clr)      ring_q <= '0;
    else if (shift_en) ring_q <= fb ^ inj;
  end

  for (genvar j = 0; j < CHAINS; j++) begin : g_phase
    assign chain_o[j] = ring_q[j % RING_W] ^ ring_q[(5*j+1) % RING_W]
                      ^ ring_q[(9*j+2) % RING_W];
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(ring_q));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ring_q == '0);
  p_zero_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_q == '0 && shift_en && !clr && tester_i == '0) |=> ring_q == '0);
  p_inject_weight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_q == '0 && shift_en && !clr)
      |=> $countones(ring_q) == 2 * $countones($past(tester_i)));
  p_zero_chains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_q == '0 |-> chain_o == '0);
endmodule

// File: tb/ring_decomp_tb.sv
`timescale 1ns/1ps
module ring_decomp_tb;
  localparam int RW = 32, IW = 4, CH = 16;
  localparam logic [RW-1:0] PM = 32'h0020_0047;

  typedef struct { logic [CH-1:0] exp; string tag; } item_t;

  logic clk = 0, rst_n = 0, clr = 0, shift_en = 0;
  logic [IW-1:0] tester_i = '0;
  logic [CH-1:0] chain_o;
  logic [RW-1:0] model = '0;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ring_decomp #(.RING_W(RW), .IN_W(IW), .CHAINS(CH), .POLY(PM)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
    .tester_i(tester_i), .chain_o(chain_o));

  function automatic logic [RW-1:0] step(logic [RW-1:0] r, logic [IW-1:0] d);
    logic [RW-1:0] n;
    for (int i = 0; i < RW - 1; i++) n[i] = r[i+1] ^ (PM[i] & r[0]);
    n[RW-1] = r[0];
    for (int k = 0; k < IW; k++) begin
      n[k*(RW/IW)] ^= d[k];
      n[k*(RW/IW) + RW/IW/2] ^= d[k];
    end
    return n;
  endfunction

  function automatic logic [CH-1:0] phase(logic [RW-1:0] r);
    logic [CH-1:0] c;
    for (int j = 0; j < CH; j++) c[j] = r[j%RW] ^ r[(5*j+1)%RW] ^ r[(9*j+2)%RW];
    return c;
  endfunction

  task automatic check(string tag, logic [CH-1:0] act, logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: chain_o=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic sh, logic c, logic [IW-1:0] d);
    item_t it;
    @(negedge clk);
    shift_en = sh; clr = c; tester_i = d;
    if (c) model = '0;
    else if (sh) model = step(model, d);
    it.exp = phase(model); it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, chain_o, it.exp);
    end
  end

  initial begin
    #1;
    check("R1", chain_o, '0);
    repeat (2) @(negedge clk);
    check("R1", chain_o, '0);
    rst_n = 1;
    // R8: zero ring, zero input
    repeat (3) drive("R8", 1, 0, '0);
    // R5: single-bit injections from a cleared ring
    for (int k = 0; k < IW; k++) begin
      drive("R3", 0, 1, '0);
      drive("R5", 1, 0, IW'(1) << k);
    end
    // R4/R7: load then free run across wraps
    drive("R3", 0, 1, '0);
    drive("R5", 1, 0, 4'b1001);
    drive("R5", 1, 0, 4'b0110);
    for (int i = 0; i < 80; i++) drive("R4", 1, 0, '0);
    // R2/R6: hold with busy data
    for (int i = 0; i < 6; i++) drive("R6", 0, 0, IW'(i * 5 + 3));
    // R3: clear beats shift and data
    drive("R3", 1, 1, 4'hF);
    drive("R8", 1, 0, '0);
    // R7: random injection stream
    for (int i = 0; i < 300; i++)
      drive("R7", ($urandom % 4) != 0, ($urandom % 50) == 0, IW'($urandom));
    drive("R2", 0, 0, 4'hA);
    drive("R2", 0, 0, 4'h5);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule